// File: doc/BRIEF.md
# Multi-Lane Daisy-Chain Converter Capture Controller

This block reads conversion results from a bank of identical serial converters wired as several daisy-chains that are sampled side by side. One active-low data-ready input represents every converter, since all of them are held in phase by a shared start/sync output. When data-ready falls, the block pulls one shared chip select low and toggles one shared serial clock. It shifts in the data-out line of every lane in the same cycle, MSB first, and samples on the rising clock edge.

At the end of a frame each lane's long shift register is cut into per-device words. All words are presented at once with a single-cycle valid strobe. A sync request holds the start output low for a set number of cycles and then re-arms capture. The default settings are four lanes of five 24-bit devices, and a serial clock of one sixth of the system clock (16.7 MHz at 100 MHz). With these settings a frame takes 720 system cycles, which fits inside a 10 µs frame period.

Top module: `daisy_capture_top`

## Requirements
- R1: After reset, cs_n_o and start_n_o are 1, sclk_o is 0, frame_valid_o and overrun_o are 0, and words_o is all zeros.
- R2: After reset, capture is disarmed. A data-ready falling edge starts no frame until a sync sequence has completed.
- R3: A one-cycle sync_req_i pulse drives start_n_o low on the next clock edge. It stays low for exactly SYNC_CYCLES clock cycles and then returns high.
- R4: When capture is armed and idle, a falling edge on drdy_n_i pulls cs_n_o low for one frame. During that frame sclk_o makes exactly LANES-independent DEVS*WORD_W = 120 rising edges. Each high and low phase of sclk_o lasts HALF_DIV clock cycles.
- R5: Each lane's data line is sampled on the sclk_o rising edge, MSB first. The word from device d of lane l appears at words_o[(l*DEVS+d)*WORD_W +: WORD_W]. Here d=0 is the device nearest the controller, whose word is shifted last, and d=DEVS-1 is the farthest device, whose word is shifted first.
- R6: frame_valid_o is high for exactly one cycle, on the cycle in which cs_n_o returns high. words_o holds its value until the next frame completes.
- R7: A drdy_n_i falling edge during a frame sets overrun_o. The frame in progress still completes with correct data. overrun_o stays set across later frames until a sync request clears it.
- R8: A sync request during a frame aborts that frame. cs_n_o returns high on the next edge and no frame_valid_o pulse follows. cs_n_o is always high while start_n_o is low.
- R9: A drdy_n_i falling edge while start_n_o is low starts no frame. The first falling edge after start_n_o is released does start one.
- R10: sclk_o is low whenever cs_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drdy_n_i | input | 1 | Shared active-low data-ready from the converters (asynchronous) |
| sync_req_i | input | 1 | One-cycle request to run a start/sync sequence |
| sdo_i | input | LANES (4) | Serial data out of the last device in each lane |
| cs_n_o | output | 1 | Shared active-low chip select |
| sclk_o | output | 1 | Shared serial clock, idle low |
| start_n_o | output | 1 | Shared active-low start/sync to all converters |
| words_o | output | LANES*DEVS*WORD_W (480) | All device words of the last frame, lane-major |
| frame_valid_o | output | 1 | One-cycle strobe when words_o updates |
| overrun_o | output | 1 | Sticky flag for data-ready arriving mid-frame |

## Verification
The frame path is driven with a table of chain contents, and each pattern targets a different fault. All-zero and all-one chains expose a stuck data line or a missing first or last bit. Alternating 0xA5/0x5A patterns expose a one-bit slip in the sampling edge or in the bit count. Patterns with the ends set, where every word is distinct by lane and device, expose swapped lanes, reversed device order and misplaced word boundaries. Directed sequences then check the disarmed state after reset, data-ready during the sync pulse, data-ready during a frame with its overrun, and a sync that aborts a frame.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

    localparam int unsigned DEF_LANES       = 4;
    localparam int unsigned DEF_DEVS        = 5;
    localparam int unsigned DEF_WORD_W      = 24;
    localparam int unsigned DEF_HALF_DIV    = 3;
    localparam int unsigned DEF_SYNC_CYCLES = 8;

    typedef enum logic [0:0] {
        CAP_IDLE  = 1'b0,
        CAP_SHIFT = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
    } serial_pins_t;

    localparam serial_pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0};

    function automatic int unsigned chain_bits(input int unsigned devs,
                                               input int unsigned word_w);
        return devs * word_w;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int unsigned HALF_DIV = adc_chain_pkg::DEF_HALF_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned DIV_W = adc_chain_pkg::cnt_width(HALF_DIV - 1);

    logic [DIV_W-1:0] phase_cnt;

    assign tick = run && (phase_cnt == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_cnt <= '0;
        end else if (tick) begin
            phase_cnt <= '0;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // R4: phase ticks never come back to back (half period of at least two cycles)
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick)
        else $error("serial clock phase shorter than two cycles");

endmodule

// File: rtl/adc_drdy_edge.sv
module adc_drdy_edge (
    input  logic clk,
    input  logic rst,
    input  logic drdy_n_async,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= drdy_n_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign fall = prev_q && !sync_q;

    // R4: one data-ready edge yields a single start event
    assert_single_fall_R4: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall)
        else $error("data-ready edge reported twice");

endmodule

// File: rtl/adc_start_sync.sv
module adc_start_sync #(
    parameter int unsigned SYNC_CYCLES = adc_chain_pkg::DEF_SYNC_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic start_n,
    output logic released
);
    localparam int unsigned SC_W = adc_chain_pkg::cnt_width(SYNC_CYCLES - 1);

    logic [SC_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_n  <= 1'b1;
            hold_cnt <= '0;
            released <= 1'b0;
        end else begin
            released <= 1'b0;
            if (req) begin
                start_n  <= 1'b0;
                hold_cnt <= SC_W'(SYNC_CYCLES - 1);
            end else if (!start_n) begin
                if (hold_cnt == '0) begin
                    start_n  <= 1'b1;
                    released <= 1'b1;
                end else begin
                    hold_cnt <= hold_cnt - 1'b1;
                end
            end
        end
    end

    // R3: a request pulls the start line low on the following edge
    assert_req_drives_low_R3: assert property (@(posedge clk) disable iff (rst)
        req |=> !start_n)
        else $error("sync request did not lower start");

    // R3: release is only reported when the line actually comes back high
    assert_release_edge_R3: assert property (@(posedge clk) disable iff (rst)
        released |-> (start_n && !$past(start_n)))
        else $error("release reported without a rising start line");

endmodule

// File: rtl/adc_lane_shift.sv
module adc_lane_shift #(
    parameter int unsigned CHAIN_W = adc_chain_pkg::DEF_DEVS * adc_chain_pkg::DEF_WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               sdo_bit,
    output logic [CHAIN_W-1:0] chain_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q <= {chain_q[CHAIN_W-2:0], sdo_bit};
        end
    end
endmodule

// File: rtl/daisy_capture_top.sv
module daisy_capture_top
    import adc_chain_pkg::*;
#(
    parameter int unsigned LANES       = DEF_LANES,
    parameter int unsigned DEVS        = DEF_DEVS,
    parameter int unsigned WORD_W      = DEF_WORD_W,
    parameter int unsigned HALF_DIV    = DEF_HALF_DIV,
    parameter int unsigned SYNC_CYCLES = DEF_SYNC_CYCLES,
    localparam int unsigned CHAIN_W    = chain_bits(DEVS, WORD_W),
    localparam int unsigned OUT_W      = LANES * CHAIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drdy_n_i,
    input  logic             sync_req_i,
    input  logic [LANES-1:0] sdo_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             start_n_o,
    output logic [OUT_W-1:0] words_o,
    output logic             frame_valid_o,
    output logic             overrun_o
);
    localparam int unsigned BIT_W = cnt_width(CHAIN_W);

    cap_state_e       state_q;
    serial_pins_t     pins_q;
    logic [BIT_W-1:0] bit_cnt_q;
    logic             armed_q;
    logic             overrun_q;
    logic             valid_q;
    logic [OUT_W-1:0] words_q;

    logic             drdy_fall;
    logic             phase_tick;
    logic             sync_released;
    logic             sample_now;
    logic [OUT_W-1:0] chains_flat;

    adc_drdy_edge u_drdy (
        .clk          (clk),
        .rst          (rst),
        .drdy_n_async (drdy_n_i),
        .fall         (drdy_fall)
    );

    adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == CAP_SHIFT && !sync_req_i),
        .tick (phase_tick)
    );

    adc_start_sync #(.SYNC_CYCLES(SYNC_CYCLES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .req      (sync_req_i),
        .start_n  (start_n_o),
        .released (sync_released)
    );

    assign sample_now = (state_q == CAP_SHIFT) && phase_tick && !pins_q.sclk && !sync_req_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        adc_lane_shift #(.CHAIN_W(CHAIN_W)) u_shift (
            .clk      (clk),
            .rst      (rst),
            .shift_en (sample_now),
            .sdo_bit  (sdo_i[g]),
            .chain_q  (chains_flat[g*CHAIN_W +: CHAIN_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= CAP_IDLE;
            pins_q    <= PINS_IDLE;
            bit_cnt_q <= '0;
            armed_q   <= 1'b0;
            overrun_q <= 1'b0;
            valid_q   <= 1'b0;
            words_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            if (sync_req_i) begin
                state_q   <= CAP_IDLE;
                pins_q    <= PINS_IDLE;
                bit_cnt_q <= '0;
                armed_q   <= 1'b0;
                overrun_q <= 1'b0;
            end else begin
                if (sync_released) begin
                    armed_q <= 1'b1;
                end
                unique case (state_q)
                    CAP_IDLE: begin
                        if (drdy_fall && armed_q) begin
                            state_q     <= CAP_SHIFT;
                            pins_q.cs_n <= 1'b0;
                            bit_cnt_q   <= '0;
                        end
                    end
                    CAP_SHIFT: begin
                        if (drdy_fall) begin
                            overrun_q <= 1'b1;
                        end
                        if (phase_tick) begin
                            if (!pins_q.sclk) begin
                                pins_q.sclk <= 1'b1;
                                bit_cnt_q   <= bit_cnt_q + 1'b1;
                            end else begin
                                pins_q.sclk <= 1'b0;
                                if (bit_cnt_q == BIT_W'(CHAIN_W)) begin
                                    pins_q.cs_n <= 1'b1;
                                    state_q     <= CAP_IDLE;
                                    valid_q     <= 1'b1;
                                    words_q     <= chains_flat;
                                end
                            end
                        end
                    end
                    default: state_q <= CAP_IDLE;
                endcase
            end
        end
    end

    assign cs_n_o        = pins_q.cs_n;
    assign sclk_o        = pins_q.sclk;
    assign words_o       = words_q;
    assign frame_valid_o = valid_q;
    assign overrun_o     = overrun_q;

    // R10: no clock activity while deselected
    assert_idle_sclk_low_R10: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o)
        else $error("serial clock high while chip select inactive");

    // R6: the valid strobe is one cycle long
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |=> !frame_valid_o)
        else $error("frame valid longer than one cycle");

    // R6: the strobe follows a selected frame
    assert_valid_after_frame_R6: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |-> (cs_n_o && !$past(cs_n_o)))
        else $error("frame valid without a closing frame");

    // R8: the converters are never read while the start line is held low
    assert_sync_blocks_cs_R8: assert property (@(posedge clk) disable iff (rst)
        !start_n_o |-> cs_n_o)
        else $error("chip select active during sync");

    // R7: overrun only clears through a sync request
    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (overrun_o && !sync_req_i) |=> overrun_o)
        else $error("overrun cleared without sync");

    // R4: bit counter never passes the frame length
    assert_bit_count_range_R4: assert property (@(posedge clk) disable iff (rst)
        bit_cnt_q <= BIT_W'(CHAIN_W))
        else $error("bit counter beyond frame length");

endmodule

// File: tb/daisy_capture_top_tb_top.sv
module daisy_capture_top_tb_top;
    import adc_chain_pkg::*;

    localparam int unsigned LANES   = DEF_LANES;
    localparam int unsigned DEVS    = DEF_DEVS;
    localparam int unsigned W       = DEF_WORD_W;
    localparam int unsigned HDIV    = DEF_HALF_DIV;
    localparam int unsigned SYNCC   = DEF_SYNC_CYCLES;
    localparam int unsigned CHAIN_W = DEVS * W;
    localparam int unsigned OUT_W   = LANES * CHAIN_W;
    localparam int          NVEC    = 6;

    // stimulus table: base word and whether each word is made distinct per lane/device
    localparam logic [23:0] VBASE [NVEC] = '{24'h000000, 24'hFFFFFF, 24'hA5A5A5,
                                              24'h5A5A5A, 24'h800001, 24'h123456};
    localparam bit          VMIX  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             drdy_n = 1'b1;
    logic             sync_req = 1'b0;
    logic [LANES-1:0] sdo;
    logic             cs_n, sclk, start_n, frame_valid, overrun;
    logic [OUT_W-1:0] words;

    always #5 clk = ~clk;

    daisy_capture_top dut_i (
        .clk           (clk),
        .rst           (rst),
        .drdy_n_i      (drdy_n),
        .sync_req_i    (sync_req),
        .sdo_i         (sdo),
        .cs_n_o        (cs_n),
        .sclk_o        (sclk),
        .start_n_o     (start_n),
        .words_o       (words),
        .frame_valid_o (frame_valid),
        .overrun_o     (overrun)
    );

    // converter chain model: bit index advances on each falling sclk
    logic [CHAIN_W-1:0] stream [LANES];
    int unsigned        bit_idx;

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) bit_idx <= 0;
        else      bit_idx <= bit_idx + 1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_model
        assign sdo[g] = (bit_idx < CHAIN_W) ? stream[g][CHAIN_W-1-bit_idx] : 1'b0;
    end

    // monitors
    int  rises = 0, hi_len = 0, last_hi = 0, cs_falls = 0, valids = 0, idle_viol = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                rises = 0;
                cs_falls++;
            end else if (!cs_n && sclk && !prev_sclk) begin
                rises++;
            end
            if (sclk) hi_len++;
            else if (prev_sclk) begin
                last_hi = hi_len;
                hi_len = 0;
            end
            if (frame_valid) valids++;
            if (cs_n && sclk) idle_viol++;
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_word(input int v, input int l, input int d);
        logic [W-1:0] w;
        w = W'(VBASE[v]);
        if (VMIX[v]) begin
            w = w ^ (W'(l * DEVS + d + 1) * W'(24'h010101)) ^ (W'(l) << (W - 4));
        end
        return w;
    endfunction

    task automatic load_vec(input int v);
        for (int l = 0; l < LANES; l++)
            for (int d = 0; d < DEVS; d++)
                stream[l][d*W +: W] = exp_word(v, l, d);
    endtask

    task automatic pulse_drdy();
        @(negedge clk) drdy_n = 1'b0;
        repeat (3) @(negedge clk);
        drdy_n = 1'b1;
    endtask

    task automatic pulse_sync();
        @(negedge clk) sync_req = 1'b1;
        @(negedge clk) sync_req = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (frame_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_words(input int v, input string req);
        for (int l = 0; l < LANES; l++)
            for (int d = 0; d < DEVS; d++)
                chk(words[(l*DEVS+d)*W +: W] == exp_word(v, l, d), req,
                    32'(words[(l*DEVS+d)*W +: W]), 32'(exp_word(v, l, d)));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        int base;
        load_vec(0);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
        chk(start_n == 1'b1, "R1 start_n", 32'(start_n), 1);
        chk(frame_valid == 1'b0 && overrun == 1'b0, "R1 valid/overrun",
            32'({frame_valid, overrun}), 0);
        chk(words == '0, "R1 words", 32'(words[31:0]), 0);

        // R2 disarmed after reset
        pulse_drdy();
        repeat (40) @(negedge clk);
        chk(cs_falls == 0, "R2 no frame before sync", 32'(cs_falls), 0);

        // R3 sync pulse length
        @(negedge clk) sync_req = 1'b1;
        @(negedge clk) sync_req = 1'b0;
        base = 0;
        while (!start_n && base < 100) begin
            base++;
            @(negedge clk);
        end
        chk(base == SYNCC, "R3 start low cycles", 32'(base), 32'(SYNCC));
        repeat (4) @(negedge clk);

        // R4 R5 R6: table of vectors
        for (int v = 0; v < NVEC; v++) begin
            load_vec(v);
            pulse_drdy();
            wait_valid(seen);
            chk(seen, "R4 frame completes", 32'(seen), 1);
            chk(rises == CHAIN_W, "R4 sclk rising edges", 32'(rises), 32'(CHAIN_W));
            chk(last_hi == HDIV, "R4 sclk high phase", 32'(last_hi), 32'(HDIV));
            chk(cs_n == 1'b1, "R6 cs_n high with valid", 32'(cs_n), 1);
            check_words(v, "R5 word placement");
            load_vec((v + 1) % NVEC);
            @(negedge clk);
            chk(frame_valid == 1'b0, "R6 valid one cycle", 32'(frame_valid), 0);
            repeat (10) @(negedge clk);
            check_words(v, "R6 words held");
        end

        // R7 overrun during a frame
        load_vec(4);
        pulse_drdy();
        while (rises < 10) @(negedge clk);
        pulse_drdy();
        wait_valid(seen);
        chk(seen, "R7 frame survives overrun", 32'(seen), 1);
        chk(overrun == 1'b1, "R7 overrun set", 32'(overrun), 1);
        check_words(4, "R7 data intact");
        repeat (5) @(negedge clk);
        load_vec(5);
        pulse_drdy();
        wait_valid(seen);
        chk(seen && overrun == 1'b1, "R7 overrun sticky", 32'(overrun), 1);
        pulse_sync();
        @(negedge clk);
        chk(overrun == 1'b0, "R7 cleared by sync", 32'(overrun), 0);
        while (!start_n) @(negedge clk);
        repeat (4) @(negedge clk);

        // R8 sync aborts a frame
        load_vec(2);
        pulse_drdy();
        while (rises < 5) @(negedge clk);
        base = valids;
        @(negedge clk) sync_req = 1'b1;
        @(negedge clk) sync_req = 1'b0;
        chk(cs_n == 1'b1, "R8 cs_n released on abort", 32'(cs_n), 1);
        chk(start_n == 1'b0, "R8 start low", 32'(start_n), 0);
        repeat (1000) @(negedge clk);
        chk(valids == base, "R8 no valid after abort", 32'(valids - base), 0);

        // R9 data-ready during sync is ignored, next one is taken
        base = cs_falls;
        pulse_sync();
        @(negedge clk) drdy_n = 1'b0;
        @(negedge clk) drdy_n = 1'b1;
        while (!start_n) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(cs_falls == base, "R9 drdy during sync ignored", 32'(cs_falls - base), 0);
        load_vec(3);
        pulse_drdy();
        wait_valid(seen);
        chk(seen, "R9 first drdy after release", 32'(seen), 1);
        check_words(3, "R9 frame data");

        // R10 sclk idle low over the whole run
        chk(idle_viol == 0, "R10 sclk low while deselected", 32'(idle_viol), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule